// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps one sticky flag per reset source so that software can find out, once the system runs again, what pulled it into reset. There are five sources: power-on, the external reset pin, the brown-out detector, the watchdog and a reset request from the debug port. Each source other than power-on reaches the block as a one-cycle event pulse. Power-on reaches it as a level input. A flag that is set stays set through later resets until software clears it, so several flags can be set at the same time.

Software reaches the flags through a byte-wide register bus that decodes one address. A read returns the flags in the low five bits, and the three upper bits always read as zero. A write clears each flag whose data bit is zero and leaves each flag whose data bit is one unchanged. Clearing is not the same for every flag. A power-on clears every flag except its own, and only a software write can clear the power-on flag. Right after a power-on, the reader should treat the external flag as meaningless.

A two-state controller tracks the power-on input. `ST_POWER` is entered, and held, whenever power-on is high. The transition POWER_RELEASE moves it to `ST_ACTIVE` at the first clock edge that samples power-on low. The transition POWER_REENTER moves it back as soon as power-on rises again. Event pulses and bus writes take effect only in `ST_ACTIVE` while power-on is low.

Top module: `reset_cause_reg`

## Requirements
- R1: A read at the register address returns debug in bit 4, watchdog in bit 3, brown-out in bit 2, external in bit 1 and power-on in bit 0.
- R2: While the power-on input is high, each clock edge sets the power-on flag and clears the other four flags, and event pulses and bus writes are ignored.
- R3: At the first clock edge after the power-on input falls, the controller is still in `ST_POWER`, so events and writes are ignored. They are accepted from the next edge on.
- R4: An event pulse on the external, brown-out, watchdog or debug input sets its own flag at the next clock edge. The flag stays set until it is cleared, and several flags can be set together.
- R5: A bus write clears each of bits 4 to 0 whose data bit is 0, at the next edge. Data bits that are 1 leave their flags unchanged.
- R6: The power-on flag is cleared only by a software write of 0 to bit 0. Event pulses never clear it.
- R7: When an event pulse and a write of 0 to the same flag happen in the same cycle, the flag ends up set.
- R8: Bits 7 to 5 always read as 0, and writes to them have no effect.
- R9: A bus access acts only when the select input is high and the address equals the register address. A write elsewhere changes nothing, and a read elsewhere returns 0.
- R10: Read data depends combinationally on the address, select and write inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| power_on_i | input | 1 | Power-on indication, active high, level |
| ext_evt_i | input | 1 | External pin reset event pulse |
| brownout_evt_i | input | 1 | Brown-out reset event pulse |
| wdog_evt_i | input | 1 | Watchdog reset event pulse |
| dbg_evt_i | input | 1 | Debug-port reset request pulse |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, 0 when not a read of this register |

## Verification
Every flag bit is a register that is visible on the bus one cycle after it changes. A wrong capture, clear or priority decision therefore shows up as a wrong bit on the very next read, and the bench reads after every stimulus. A controller stuck in the wrong state shows up as one of two errors. Either an event given at the release edge is captured when it should be dropped, or an event given later is lost. A read right after that edge shows either error.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
    localparam int NUM_FLAGS = 5;
    localparam int FLAG_POR  = 0;
    localparam int FLAG_EXT  = 1;
    localparam int FLAG_BOD  = 2;
    localparam int FLAG_WDT  = 3;
    localparam int FLAG_DBG  = 4;

    typedef enum logic [0:0] {
        ST_POWER  = 1'b0,
        ST_ACTIVE = 1'b1
    } pwr_state_t;
endpackage

// File: rtl/rcr_power_fsm.sv
module rcr_power_fsm
    import rcr_pkg::*;
(
    input  logic clk_i,
    input  logic por_i,
    output logic accept_o
);
    pwr_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWER:  if (!por_i) state_d = ST_ACTIVE;  // POWER_RELEASE
            ST_ACTIVE: if (por_i)  state_d = ST_POWER;   // POWER_REENTER
            default:   state_d = ST_POWER;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (por_i) state_q <= ST_POWER;
        else       state_q <= state_d;
    end

    always_comb begin
        accept_o = 1'b0;
        unique case (state_q)
            ST_POWER:  accept_o = 1'b0;
            ST_ACTIVE: accept_o = !por_i;
            default:   accept_o = 1'b0;
        endcase
    end

    // R3
    first_edge_ignore_chk: assert property (@(posedge clk_i) disable iff (por_i)
        $past(por_i) |-> !accept_o);
    // R3
    later_edge_accept_chk: assert property (@(posedge clk_i) disable iff (por_i)
        !$past(por_i) |-> accept_o);
endmodule

// File: rtl/rcr_flag_cell.sv
module rcr_flag_cell #(
    parameter bit SET_ON_POR = 1'b0
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk_i) begin
        if (por_i)      q_o <= SET_ON_POR;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk_i) disable iff (por_i)
        set_i |=> q_o);
    // R5
    clear_takes_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (clr_i && !set_i) |=> !q_o);
    // R4
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (q_o && !clr_i) |=> q_o);
    // R2
    por_value_chk: assert property (@(posedge clk_i) disable iff (por_i)
        $past(por_i) |-> (q_o == SET_ON_POR));
endmodule

// File: rtl/rcr_bus_port.sv
module rcr_bus_port #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int NUM_FLAGS = 5,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic                 clk_i,
    input  logic                 por_i,
    input  logic                 sel_i,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [NUM_FLAGS-1:0] flags_i,
    output logic [NUM_FLAGS-1:0] clr_req_o,
    output logic [DATA_W-1:0]    rdata_o
);
    localparam int RSV_W = DATA_W - NUM_FLAGS;

    logic hit;
    assign hit = sel_i && (addr_i == REG_ADDR);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_clr
        assign clr_req_o[i] = hit && we_i && !wdata_i[i];
    end

    always_comb begin
        rdata_o = '0;
        if (hit && !we_i) rdata_o[NUM_FLAGS-1:0] = flags_i;
    end

    // R8
    reserved_write_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (hit && we_i && (&wdata_i[NUM_FLAGS-1:0]) && (|wdata_i[DATA_W-1:DATA_W-RSV_W]))
        |=> ((flags_i & $past(flags_i)) == $past(flags_i)));
    // R9
    idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (por_i)
        !hit |-> (rdata_o == '0));
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
    import rcr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h34
) (
    input  logic              clk_i,
    input  logic              power_on_i,
    input  logic              ext_evt_i,
    input  logic              brownout_evt_i,
    input  logic              wdog_evt_i,
    input  logic              dbg_evt_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o
);
    logic                 accept;
    logic [NUM_FLAGS-1:0] raw_evt;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_req;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flags;

    rcr_power_fsm u_fsm (
        .clk_i    (clk_i),
        .por_i    (power_on_i),
        .accept_o (accept)
    );

    always_comb begin
        raw_evt           = '0;
        raw_evt[FLAG_EXT] = ext_evt_i;
        raw_evt[FLAG_BOD] = brownout_evt_i;
        raw_evt[FLAG_WDT] = wdog_evt_i;
        raw_evt[FLAG_DBG] = dbg_evt_i;
    end

    assign set_vec = raw_evt & {NUM_FLAGS{accept}};
    assign clr_vec = clr_req & {NUM_FLAGS{accept}};

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        rcr_flag_cell #(.SET_ON_POR(i == FLAG_POR)) u_cell (
            .clk_i (clk_i),
            .por_i (power_on_i),
            .set_i (set_vec[i]),
            .clr_i (clr_vec[i]),
            .q_o   (flags[i])
        );
    end

    rcr_bus_port #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_FLAGS (NUM_FLAGS),
        .REG_ADDR  (REG_ADDR)
    ) u_bus (
        .clk_i     (clk_i),
        .por_i     (power_on_i),
        .sel_i     (bus_sel_i),
        .we_i      (bus_we_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .flags_i   (flags),
        .clr_req_o (clr_req),
        .rdata_o   (bus_rdata_o)
    );

    // R6
    por_flag_keep_chk: assert property (@(posedge clk_i) disable iff (power_on_i)
        !clr_vec[FLAG_POR] |=> !$fell(flags[FLAG_POR]));
endmodule

// File: tb/sim_reset_cause_reg.sv
module sim_reset_cause_reg;
    localparam logic [7:0] RA = 8'h34;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       ext = 1'b0, bod = 1'b0, wdt = 1'b0, dbg = 1'b0;
    logic       sel = 1'b0, we = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    reset_cause_reg u0 (
        .clk_i(clk), .power_on_i(por), .ext_evt_i(ext), .brownout_evt_i(bod),
        .wdog_evt_i(wdt), .dbg_evt_i(dbg), .bus_sel_i(sel), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
    );

    // drive one cycle; evt = {dbg, wdt, bod, ext}
    task automatic cyc(input logic p, input logic [3:0] evt, input logic s,
                       input logic w, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        por = p; {dbg, wdt, bod, ext} = evt;
        sel = s; we = w; addr = a; wdata = d;
    endtask

    task automatic rd(input logic p, input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        por = p; {dbg, wdt, bod, ext} = 4'b0;
        sel = 1'b1; we = 1'b0; addr = a; wdata = 8'h00;
    endtask

    // monitor: pops one expected value per read cycle
    always @(negedge clk) begin
        #2;
        if (sel && !we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: actual=%02h expected=none", rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual=%02h expected=%02h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(1, 4'b0000, 0, 0, RA, 8'h00);
        cyc(1, 4'b1111, 0, 0, RA, 8'h00);          // R2 events ignored in power-on
        cyc(1, 4'b0000, 1, 1, RA, 8'hFF);          // R2 write ignored in power-on
        rd (1, RA, 8'h01, "R2 reset state");
        cyc(0, 4'b0001, 0, 0, RA, 8'h00);          // R3 release edge, ext dropped
        rd (0, RA, 8'h01, "R3 release edge ignores event");
        cyc(0, 4'b0001, 0, 0, RA, 8'h00);
        rd (0, RA, 8'h03, "R4 external flag");
        cyc(0, 4'b0010, 0, 0, RA, 8'h00);
        rd (0, RA, 8'h07, "R4 brown-out flag");
        cyc(0, 4'b0100, 0, 0, RA, 8'h00);
        rd (0, RA, 8'h0F, "R4 watchdog flag");
        cyc(0, 4'b1000, 0, 0, RA, 8'h00);
        rd (0, RA, 8'h1F, "R1 all flags bit map");
        cyc(0, 4'b0000, 1, 1, RA, 8'hFF);
        rd (0, RA, 8'h1F, "R8 ones and reserved write no effect");
        cyc(0, 4'b0000, 1, 1, RA, 8'hFD);
        rd (0, RA, 8'h1D, "R5 clear external only");
        cyc(0, 4'b0000, 1, 1, 8'h35, 8'h00);
        rd (0, RA, 8'h1D, "R9 write to other address");
        rd (0, 8'h35, 8'h00, "R9 read of other address");
        cyc(0, 4'b0000, 0, 1, RA, 8'h00);
        rd (0, RA, 8'h1D, "R9 write without select");
        cyc(0, 4'b0100, 1, 1, RA, 8'h00);          // R7 watchdog set vs clear
        rd (0, RA, 8'h08, "R7 set wins, R6 power-on cleared by write");
        cyc(0, 4'b0010, 0, 0, RA, 8'h00);
        rd (0, RA, 8'h0C, "R6 event leaves power-on clear");
        cyc(1, 4'b1000, 0, 0, RA, 8'h00);          // power-on pulse
        rd (0, RA, 8'h01, "R2 power-on clears others");
        cyc(0, 4'b1000, 0, 0, RA, 8'h00);
        rd (0, RA, 8'h11, "R4 debug flag after power-on");
        cyc(0, 4'b0001, 0, 0, RA, 8'h00);
        rd (0, RA, 8'h13, "R6 power-on flag survives events");
        cyc(0, 4'b0000, 1, 1, RA, 8'hFE);
        rd (0, RA, 8'h12, "R5 clear power-on flag only");
        cyc(0, 4'b0000, 1, 1, RA, 8'hE0);
        rd (0, RA, 8'h00, "R10 read after clear all");
        cyc(0, 4'b0000, 0, 0, RA, 8'h00);
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 pending reads: actual=%0d expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule